// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timer

This block derives the serial clock and the active-low chip select of a quad serial flash port from the faster system clock. A command sequencer asks for a transfer with a one-cycle start pulse and marks the final bit with a one-cycle stop pulse. The block returns two single-cycle strobes, aligned to the system clock, that tell the sequencer when to put the next bit on the lines and when to capture read data.

All timing is set by static controls. These are a clock divider, a short or long chip-select lead, a short or long chip-select trail, a minimum chip-select high gap, a post-transfer keep-low window, the clock idle level and a duty-cycle fix for odd dividers. Shifting data and framing commands are done elsewhere.

A controller with seven states does the sequencing. IDLE waits with chip select high. GAP holds chip select high for the minimum gap, then goes to IDLE, or goes straight to a new transfer if a start is waiting. SETUP is the extra lead of one serial period. LOW and HIGH are the two halves of each serial clock period: LOW goes to HIGH, and HIGH goes back to LOW unless the stop request has arrived. HOLD is the extra trail of one serial period. EXT keeps chip select low after a transfer. From EXT a waiting start goes straight to LOW, and an expired window goes to GAP.

When the trail ends, the next state is GAP if no extension is selected, and EXT if one is. A start seen in IDLE, or at the end of GAP, goes to SETUP for a long lead and to LOW for a short lead.

Top module: `sflash_clk_cs_timer`

## Requirements
- R1: The serial clock period is D system clocks, where D is the divider input clamped to the range 2 to 64. A divider below 2 acts as 2 and one above 64 acts as 64.
- R2: With the duty fix off, or with an even D, each period has a low half of ceil(D/2) system clocks followed by a high half of floor(D/2) system clocks.
- R3: With the duty fix on and D odd, every rising edge of the serial clock comes half a system clock later, so each half lasts D/2 system clocks.
- R4: With mode bit 0 the serial clock rests low when it is not toggling, and with mode bit 1 it rests high. Every period starts with its low half.
- R5: Chip select falls one low half before the first rising edge when the lead bit is 0. When the lead bit is 1 it falls one period plus one low half before that edge.
- R6: Chip select rises one high half after the last rising edge when the trail bit is 0. When the trail bit is 1 it rises one period plus one high half after that edge.
- R7: After chip select rises it stays high for at least (G+1)·D system clocks, where G is the 4-bit gap code. A start that is waiting when this time ends drops chip select in exactly that cycle.
- R8: The 2-bit extension code sets how long chip select stays low after the trail. Code 0 adds nothing, code 1 adds 32·D system clocks, code 2 adds 128·D, and code 3 keeps it low until the next start. A start that arrives during the extension begins the next transfer with chip select still low.
- R9: The drive strobe is high for one system clock at the start of each low half of a transfer. The sample strobe is high for one system clock at the start of each high half. Neither strobe fires while chip select is high.
- R10: A stop pulse makes the rising edge that starts in the same cycle, or the next one to start, the last of the transfer. A stop pulse in the cycle of the k-th sample strobe therefore gives exactly k rising edges.
- R11: After reset, chip select is high, both strobes are low and the block waits in IDLE for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_i | input | DIV_W | Serial clock divider, clamped to 2..64 |
| setup_long_i | input | 1 | 1 selects the long chip-select lead |
| hold_long_i | input | 1 | 1 selects the long chip-select trail |
| gap_i | input | GAP_W | Minimum high gap, in serial periods, minus one |
| ext_i | input | 2 | Keep-low window: 0 none, 1 short, 2 long, 3 until next start |
| mode3_i | input | 1 | 1 makes the serial clock rest high |
| duty_fix_i | input | 1 | Delays rising edges by half a system clock when D is odd |
| start_i | input | 1 | One-cycle transfer request, held pending until served |
| stop_i | input | 1 | One-cycle marker for the final rising edge |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| drive_stb_o | output | 1 | Start of a low half: present the next bit |
| sample_stb_o | output | 1 | Start of a high half: capture input lines |

## Verification
Directed transfers use dividers of 2 and 3, an odd divider with and without the duty fix, both clock rest levels, and out-of-range dividers that must clamp. These cases separate a half-cycle timing error from a whole-cycle one, and a clamp from a wrap. Random transfers then mix the divider, lead, trail, gap code, extension code and the position of the stop pulse. Edge timestamps are compared with the formulas in the requirements, which catches a wrong lead, trail, gap or extension count on its own. A separate case holds chip select low indefinitely and then continues with a second transfer, to confirm that chip select never rises between the two.

// File: rtl/sfc_pkg.sv
`timescale 1ns/1ps
package sfc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GAP,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_HOLD,
        ST_EXT
    } sfc_state_e;

    localparam logic [1:0] EXT_CODE_NONE  = 2'd0;
    localparam logic [1:0] EXT_CODE_SHORT = 2'd1;
    localparam logic [1:0] EXT_CODE_LONG  = 2'd2;
    localparam logic [1:0] EXT_CODE_KEEP  = 2'd3;
endpackage

// File: rtl/sfc_len_calc.sv
`timescale 1ns/1ps
module sfc_len_calc import sfc_pkg::*; #(
    parameter int DIV_W     = 7,
    parameter int GAP_W     = 4,
    parameter int CNT_W     = 14,
    parameter int MIN_DIV   = 2,
    parameter int MAX_DIV   = 64,
    parameter int EXT_SHORT = 32,
    parameter int EXT_LONG  = 128
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic             duty_fix_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic [1:0]       ext_i,
    output logic [CNT_W-1:0] per_len_o,
    output logic [CNT_W-1:0] low_len_o,
    output logic [CNT_W-1:0] high_len_o,
    output logic [CNT_W-1:0] gap_len_o,
    output logic [CNT_W-1:0] ext_len_o,
    output logic             duty_act_o
);
    logic [CNT_W-1:0] div_c;
    logic [CNT_W-1:0] half_dn;
    logic [CNT_W-1:0] half_up;

    always_comb begin
        if (div_i < DIV_W'(MIN_DIV)) begin
            div_c = CNT_W'(MIN_DIV);
        end else if (div_i > DIV_W'(MAX_DIV)) begin
            div_c = CNT_W'(MAX_DIV);
        end else begin
            div_c = CNT_W'(div_i);
        end
        half_dn    = div_c >> 1;
        half_up    = half_dn + CNT_W'(div_c[0]);
        duty_act_o = duty_fix_i & div_c[0];
        per_len_o  = div_c;
        // the fix moves half a system clock from the low half to the high half
        low_len_o  = duty_act_o ? half_dn : half_up;
        high_len_o = duty_act_o ? half_up : half_dn;
        gap_len_o  = div_c * (CNT_W'(gap_i) + CNT_W'(1));
        unique case (ext_i)
            EXT_CODE_SHORT: ext_len_o = div_c * CNT_W'(EXT_SHORT);
            EXT_CODE_LONG:  ext_len_o = div_c * CNT_W'(EXT_LONG);
            default:        ext_len_o = '0;
        endcase
    end
endmodule

// File: rtl/sfc_sck_out.sv
`timescale 1ns/1ps
module sfc_sck_out (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    input  logic duty_act_i,
    output logic sck_o
);
    logic half_q;

    // copy taken on the falling system edge, half a cycle behind raw_i
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            half_q <= 1'b0;
        end else begin
            half_q <= raw_i;
        end
    end

    // AND delays only rising transitions; falling ones pass at once
    assign sck_o = duty_act_i ? (raw_i & half_q) : raw_i;
endmodule

// File: rtl/sflash_clk_cs_timer.sv
`timescale 1ns/1ps
module sflash_clk_cs_timer import sfc_pkg::*; #(
    parameter int DIV_W     = 7,
    parameter int GAP_W     = 4,
    parameter int MIN_DIV   = 2,
    parameter int MAX_DIV   = 64,
    parameter int EXT_SHORT = 32,
    parameter int EXT_LONG  = 128
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             setup_long_i,
    input  logic             hold_long_i,
    input  logic [GAP_W-1:0] gap_i,
    input  logic [1:0]       ext_i,
    input  logic             mode3_i,
    input  logic             duty_fix_i,
    input  logic             start_i,
    input  logic             stop_i,
    output logic             sck_o,
    output logic             cs_no,
    output logic             drive_stb_o,
    output logic             sample_stb_o
);
    localparam int CNT_W = $clog2(MAX_DIV * EXT_LONG) + 1;

    logic [CNT_W-1:0] per_len, low_len, high_len, gap_len, ext_len;
    logic             duty_act;

    sfc_len_calc #(
        .DIV_W(DIV_W), .GAP_W(GAP_W), .CNT_W(CNT_W), .MIN_DIV(MIN_DIV),
        .MAX_DIV(MAX_DIV), .EXT_SHORT(EXT_SHORT), .EXT_LONG(EXT_LONG)
    ) u_len (
        .div_i(div_i), .duty_fix_i(duty_fix_i), .gap_i(gap_i), .ext_i(ext_i),
        .per_len_o(per_len), .low_len_o(low_len), .high_len_o(high_len),
        .gap_len_o(gap_len), .ext_len_o(ext_len), .duty_act_o(duty_act)
    );

    sfc_state_e       state_q, state_d, prev_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             start_pend_q, start_pend_d, stop_pend_q, stop_pend_d;
    logic             keep_q, keep_d;
    logic             start_take, stop_take, go, last, cnt_zero, in_xfer;
    sfc_state_e       rel_state;
    logic [CNT_W-1:0] rel_cnt;
    logic             sck_raw, entered;

    assign go       = start_i | start_pend_q;
    assign last     = stop_i | stop_pend_q;
    assign cnt_zero = (cnt_q == '0);
    assign in_xfer  = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);

    // destination once the trail is done
    always_comb begin
        if (ext_i == EXT_CODE_NONE) begin
            rel_state = ST_GAP;
            rel_cnt   = gap_len - CNT_W'(1);
        end else begin
            rel_state = ST_EXT;
            rel_cnt   = ext_len - CNT_W'(1);
        end
    end

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_zero ? cnt_q : cnt_q - CNT_W'(1);
        keep_d     = keep_q;
        start_take = 1'b0;
        stop_take  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_GAP: begin
                if (state_q == ST_IDLE || cnt_zero) begin
                    if (go) begin
                        start_take = 1'b1;
                        state_d    = setup_long_i ? ST_SETUP : ST_LOW;
                        cnt_d      = setup_long_i ? per_len - CNT_W'(1) : low_len - CNT_W'(1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    state_d = ST_LOW;
                    cnt_d   = low_len - CNT_W'(1);
                end
            end
            ST_LOW: begin
                if (cnt_zero) begin
                    state_d = ST_HIGH;
                    cnt_d   = high_len - CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (cnt_zero) begin
                    if (last) begin
                        stop_take = 1'b1;
                        if (hold_long_i) begin
                            state_d = ST_HOLD;
                            cnt_d   = per_len - CNT_W'(1);
                        end else begin
                            state_d = rel_state;
                            cnt_d   = rel_cnt;
                            keep_d  = (ext_i == EXT_CODE_KEEP);
                        end
                    end else begin
                        state_d = ST_LOW;
                        cnt_d   = low_len - CNT_W'(1);
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_zero) begin
                    state_d = rel_state;
                    cnt_d   = rel_cnt;
                    keep_d  = (ext_i == EXT_CODE_KEEP);
                end
            end
            ST_EXT: begin
                if (go) begin
                    start_take = 1'b1;
                    state_d    = ST_LOW;
                    cnt_d      = low_len - CNT_W'(1);
                end else if (!keep_q && cnt_zero) begin
                    state_d = ST_GAP;
                    cnt_d   = gap_len - CNT_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
        start_pend_d = (start_pend_q | start_i) & ~start_take;
        stop_pend_d  = (stop_pend_q | (stop_i & in_xfer)) & ~stop_take;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q      <= ST_IDLE;
            prev_q       <= ST_IDLE;
            cnt_q        <= '0;
            start_pend_q <= 1'b0;
            stop_pend_q  <= 1'b0;
            keep_q       <= 1'b0;
        end else begin
            state_q      <= state_d;
            prev_q       <= state_q;
            cnt_q        <= cnt_d;
            start_pend_q <= start_pend_d;
            stop_pend_q  <= stop_pend_d;
            keep_q       <= keep_d;
        end
    end

    always_comb begin
        entered      = (state_q != prev_q);
        cs_no        = (state_q == ST_IDLE) || (state_q == ST_GAP);
        drive_stb_o  = (state_q == ST_LOW) && entered;
        sample_stb_o = (state_q == ST_HIGH) && entered;
        sck_raw      = mode3_i ? (state_q != ST_LOW) : (state_q == ST_HIGH);
    end

    sfc_sck_out u_sck (
        .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(sck_raw),
        .duty_act_i(duty_act), .sck_o(sck_o)
    );

    assert_no_stb_cs_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_no |-> !(drive_stb_o || sample_stb_o));
    assert_stb_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_stb_o |=> !sample_stb_o);
    assert_min_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cs_no) |=> cs_no);
    assert_phase_cnt_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOW || state_q == ST_HIGH) |-> (cnt_q < CNT_W'(MAX_DIV)));
    assert_stop_in_xfer_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_pend_q |-> !cs_no);
endmodule

// File: tb/sflash_clk_cs_timer_tb_top.sv
`timescale 1ns/1ps
module sflash_clk_cs_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] div = 7'd2;
    logic       su = 1'b0, ho = 1'b0, m3 = 1'b0, du = 1'b0, start = 1'b0, stop = 1'b0;
    logic [3:0] gap = 4'd0;
    logic [1:0] ext = 2'd0;
    logic       sck, cs_n, dstb, sstb;

    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    sflash_clk_cs_timer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .div_i(div), .setup_long_i(su), .hold_long_i(ho),
        .gap_i(gap), .ext_i(ext), .mode3_i(m3), .duty_fix_i(du), .start_i(start),
        .stop_i(stop), .sck_o(sck), .cs_no(cs_n), .drive_stb_o(dstb), .sample_stb_o(sstb)
    );

    longint t_cs_fall = 0, t_cs_rise = 0, t_first = 0, t_last = 0, t_fall = 0, t_rise = 0;
    longint exp_lw = 0, exp_hw = 0, gap_act = 0;
    int     n_rise = 0, cs_rises = 0, lw_bad = 0, hw_bad = 0, n_drv = 0, n_smp = 0;
    bit     first = 1'b0, fall_open = 1'b0, rise_open = 1'b0, gap_valid = 1'b0;
    int     cur_dc = 2, cur_g = 0, prev_dc = 2, prev_g = 0;
    bit     cur_duty = 1'b0;

    always @(negedge cs_n) t_cs_fall = $time;
    always @(posedge cs_n) begin t_cs_rise = $time; cs_rises++; end
    always @(posedge sck) begin
        if (fall_open && ($time - t_fall) != exp_lw) lw_bad++;
        fall_open = 1'b0; rise_open = 1'b1; t_rise = $time;
        if (first) begin t_first = $time; first = 1'b0; end
        t_last = $time; n_rise++;
    end
    always @(negedge sck) begin
        if (rise_open && ($time - t_rise) != exp_hw) hw_bad++;
        rise_open = 1'b0; fall_open = 1'b1; t_fall = $time;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clampd(input int d);
        return (d < 2) ? 2 : ((d > 64) ? 64 : d);
    endfunction
    function automatic longint low_ns(input int dc, input bit dfix);
        return (dfix && dc % 2 == 1) ? longint'(dc * 4) : longint'(((dc + 1) / 2) * 8);
    endfunction
    function automatic longint high_ns(input int dc, input bit dfix);
        return (dfix && dc % 2 == 1) ? longint'(dc * 4) : longint'((dc / 2) * 8);
    endfunction
    function automatic longint ext_ns(input int dc, input int e);
        return (e == 1) ? longint'(32 * dc * 8) : ((e == 2) ? longint'(128 * dc * 8) : 0);
    endfunction

    // called at a negedge; configures, then pulses start one cycle later
    task automatic issue(input int dv, input bit s, input bit h, input int g, input int e,
                         input bit m, input bit df);
        div = 7'(dv); su = s; ho = h; gap = 4'(g); ext = 2'(e); m3 = m; du = df;
        cur_dc = clampd(dv); cur_g = g; cur_duty = df;
        exp_lw = low_ns(cur_dc, df); exp_hw = high_ns(cur_dc, df);
        @(negedge clk);
        first = 1'b1; fall_open = 1'b0; rise_open = 1'b0;
        n_rise = 0; lw_bad = 0; hw_bad = 0; n_drv = 0; n_smp = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic track(input int k, input bit to_release);
        bit seen = 1'b0;
        forever begin
            if (dstb) n_drv++;
            if (sstb) n_smp++;
            stop = sstb && (n_smp == k);
            if (!cs_n) begin
                if (!seen) gap_act = t_cs_fall - t_cs_rise;
                seen = 1'b1;
            end else if (seen) begin
                break;
            end
            if (!to_release && n_smp == k && !stop) break;
            @(negedge clk);
        end
        stop = 1'b0;
    endtask

    task automatic run_xfer(input int dv, input bit s, input bit h, input int g, input int e,
                            input bit m, input bit df, input int k);
        string wtag;
        longint exp_su, exp_ho;
        issue(dv, s, h, g, e, m, df);
        track(k, 1'b1);
        wtag = (dv < 2 || dv > 64) ? "R1" : ((df && cur_dc % 2 == 1) ? "R3" : "R2");
        exp_su = exp_lw + (s ? longint'(cur_dc * 8) : 0);
        exp_ho = exp_hw + (h ? longint'(cur_dc * 8) : 0) + ext_ns(cur_dc, e);
        chk((t_first - t_cs_fall) == exp_su, "R5", "setup ns", t_first - t_cs_fall, exp_su);
        chk((t_cs_rise - t_last) == exp_ho, (e == 0) ? "R6" : "R8", "trail ns",
            t_cs_rise - t_last, exp_ho);
        chk(n_rise == k, "R10", "rising edges", n_rise, k);
        chk(n_drv == k && n_smp == k, "R9", "strobe counts", n_drv * 1000 + n_smp, k * 1001);
        chk(lw_bad == 0, wtag, "bad low halves", lw_bad, 0);
        chk(hw_bad == 0, wtag, "bad high halves", hw_bad, 0);
        chk(sck == m, "R4", "rest level", sck, m);
        if (gap_valid) begin
            chk(gap_act == longint'(prev_dc * (prev_g + 1) * 8), "R7", "gap ns", gap_act,
                longint'(prev_dc * (prev_g + 1) * 8));
        end
        prev_dc = cur_dc; prev_g = g; gap_valid = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int r0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && dstb == 1'b0 && sstb == 1'b0, "R11", "reset outputs",
            {cs_n, dstb, sstb}, 3'b100);
        chk(sck == 1'b0, "R11", "reset clock level", sck, 0);

        run_xfer(2, 0, 0, 0, 0, 0, 0, 1);
        run_xfer(3, 1, 1, 0, 0, 0, 1, 3);
        run_xfer(3, 0, 0, 2, 0, 0, 0, 2);
        run_xfer(5, 1, 0, 1, 0, 1, 1, 4);
        run_xfer(5, 0, 1, 0, 0, 1, 0, 2);
        run_xfer(1, 0, 0, 0, 0, 0, 0, 3);
        run_xfer(100, 1, 1, 3, 0, 0, 1, 2);
        run_xfer(7, 0, 0, 15, 0, 1, 1, 1);
        run_xfer(2, 0, 0, 0, 1, 0, 0, 2);
        run_xfer(3, 0, 1, 0, 2, 1, 1, 1);

        // indefinite keep-low, then a chained transfer with no release between
        r0 = cs_rises;
        issue(4, 0, 0, 1, 3, 0, 0);
        track(2, 1'b0);
        repeat (300) @(negedge clk);
        chk(cs_n == 1'b0 && cs_rises == r0, "R8", "held low", cs_rises - r0, 0);
        issue(4, 0, 0, 1, 0, 0, 0);
        track(3, 1'b1);
        chk(cs_rises == r0 + 1, "R8", "releases over chain", cs_rises - r0, 1);
        chk(n_drv == 3 && n_smp == 3, "R9", "chained strobes", n_drv * 1000 + n_smp, 3003);
        chk((t_cs_rise - t_last) == exp_hw, "R6", "chained trail", t_cs_rise - t_last, exp_hw);
        prev_dc = 4; prev_g = 1;

        for (int i = 0; i < 40; i++) begin
            int dv = 2 + int'($urandom % 8);
            int pick = int'($urandom % 8);
            int e = (pick == 6) ? 1 : ((pick == 7) ? 2 : 0);
            run_xfer(dv, 1'($urandom), 1'($urandom), int'($urandom % 16), e,
                     1'($urandom), 1'($urandom), 1 + int'($urandom % 6));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule